// File: doc/BRIEF.md
# Framed Serial Monitor-Word Streamer

This block sends a short, fixed burst of monitor data out of a single serial pin once per compute pass. A start pulse, raised when the sampling sequencer enters its settle state, makes the block capture four parallel 32-bit words at once. It then shifts them out one bit per clock. A one-cycle flag marks the start of each word on a separate pin.

The whole burst sits inside a fixed window of 140 clocks, and a busy output covers exactly that window. Four flagged words take 4 × 33 = 132 clocks. The eight clocks left over are idle. Because the window is fixed, the burst always ends before the next compute pass begins. The words are captured at the start pulse, so the source may change them freely while a burst is in flight.

Top module: `rtm_streamer`

## Requirements
- R1: On a clock edge where `start_i` is high and `busy_o` is low, `busy_o` rises in the next cycle. It then stays high for exactly 140 cycles, counted as window cycles 0 to 139.
- R2: `flag_o` is high for a single cycle in window cycles 0, 33, 66 and 99, and low in every other cycle. `ser_o` is low whenever `flag_o` is high.
- R3: In window cycle 33k+1+b, with k from 0 to 3 and b from 0 to 31, `ser_o` carries bit b of word k. Word k is `words_i[32k+31:32k]`, so bit 0 goes first and bit 31 last.
- R4: In window cycles 132 to 139, `flag_o` and `ser_o` are both low while `busy_o` is still high.
- R5: The words are captured on the accepting edge. Changes to `words_i` after that edge do not change the burst in flight.
- R6: A start pulse that arrives while `busy_o` is high is ignored. The window is neither restarted nor lengthened, and the data is unaffected.
- R7: While `busy_o` is low, and during reset, `ser_o` and `flag_o` are low. Reset clears `busy_o`.
- R8: A start pulse in the first cycle after `busy_o` falls is accepted and begins a new, complete burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Burst request; sampled on the rising clock edge |
| words_i | input | 128 | Four data words; word k sits in bits 32k+31:32k |
| ser_o | output | 1 | Serial data, least significant bit first |
| flag_o | output | 1 | One-cycle marker before each word |
| busy_o | output | 1 | High for the 140-cycle window |

## Verification
The bench runs several word patterns and compares every cycle of each window against a model built from the frame layout. A design with an off-by-one flag position, or one that sends bits MSB first, fails on the walking-bit and alternating patterns. A start pulse in the middle of a burst, together with corrupted inputs at the same moment, exposes a design that restarts its window or reads the live inputs instead of a captured copy. The idle tail and a start pulse placed right after busy falls catch a window of the wrong length, data that leaks into the tail, and a design that loses the back-to-back request.

// File: rtl/rtm_streamer.sv
module rtm_streamer #(
  parameter int WORDS  = 4,
  parameter int WIDTH  = 32,
  parameter int WINDOW = 140
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [WORDS*WIDTH-1:0]   words_i,
  output logic                     ser_o,
  output logic                     flag_o,
  output logic                     busy_o
);
  localparam int TOTAL = WORDS * WIDTH;
  localparam int BURST = WORDS * (WIDTH + 1);
  localparam int CW    = $clog2(WINDOW + 1);
  localparam int PW    = $clog2(WIDTH + 1);
  localparam int WW    = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic             busy_q, done_q;
  logic [CW-1:0]    cyc_q;
  logic [PW-1:0]    pos_q;
  logic [WW-1:0]    wrd_q;
  logic [TOTAL-1:0] sh_q;

  wire sending = busy_q && !done_q;
  wire last_win = (cyc_q == CW'(WINDOW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cyc_q  <= '0;
      pos_q  <= '0;
      wrd_q  <= '0;
      sh_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        cyc_q  <= '0;
        pos_q  <= '0;
        wrd_q  <= '0;
        sh_q   <= words_i;
      end
    end else begin
      cyc_q <= cyc_q + 1'b1;
      if (last_win) busy_q <= 1'b0;
      if (!done_q) begin
        if (pos_q == '0) begin
          pos_q <= PW'(1);
        end else begin
          sh_q <= sh_q >> 1;
          if (pos_q == PW'(WIDTH)) begin
            pos_q <= '0;
            if (wrd_q == WW'(WORDS - 1)) done_q <= 1'b1;
            else wrd_q <= wrd_q + 1'b1;
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign flag_o = sending && (pos_q == '0);
  assign ser_o  = sending && (pos_q != '0) && sh_q[0];

  initial begin
    if (BURST > WINDOW) $error("burst does not fit in window");
  end

  logic [CW-1:0] blen_q;
  logic [WW:0]   fcnt_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blen_q <= '0;
      fcnt_q <= '0;
    end else if (busy_o) begin
      blen_q <= blen_q + 1'b1;
      if (flag_o) fcnt_q <= fcnt_q + 1'b1;
    end else begin
      blen_q <= '0;
      fcnt_q <= '0;
    end
  end

  // R1
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> blen_q == CW'(WINDOW));
  // R1
  busy_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> blen_q < CW'(WINDOW));
  // R2
  flag_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> fcnt_q == (WW+1)'(WORDS));
  // R2
  flag_data_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o |-> !ser_o);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!ser_o && !flag_o));
  // R6
  rise_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
endmodule

// File: tb/rtm_streamer_tb_top.sv
`timescale 1ns/1ps
module rtm_streamer_tb_top;
  localparam int WORDS = 4, WIDTH = 32, WINDOW = 140;
  localparam int SLOT = WIDTH + 1;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [WORDS*WIDTH-1:0] words_i = '0;
  logic ser_o, flag_o, busy_o;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  rtm_streamer #(.WORDS(WORDS), .WIDTH(WIDTH), .WINDOW(WINDOW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .words_i(words_i),
    .ser_o(ser_o), .flag_o(flag_o), .busy_o(busy_o));

  localparam logic [127:0] VEC [4] = '{
    128'h0000_0001_8000_0000_0000_0001_8000_0000,
    128'hAAAA_AAAA_5555_5555_FFFF_0000_0F0F_F0F0,
    128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
    128'h1234_5678_9ABC_DEF0_CAFE_F00D_0000_0000
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // mode 0 plain, 1 mid-burst start + input corruption, 2 start asserted at window end
  task automatic run_burst(input logic [127:0] w, input int mode, input string tag);
    int ferr = 0, derr = 0, berr = 0, terr = 0;
    words_i = w;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c < WINDOW; c++) begin
      bit ef, ed;
      ef = (c < WORDS*SLOT) && (c % SLOT == 0);
      ed = (c < WORDS*SLOT) && (c % SLOT != 0) && w[(c/SLOT)*WIDTH + (c%SLOT) - 1];
      if (busy_o !== 1'b1) berr++;
      if (flag_o !== ef) ferr++;
      if (ser_o !== ed) derr++;
      if (c >= WORDS*SLOT && (flag_o !== 1'b0 || ser_o !== 1'b0)) terr++;
      if (mode == 1 && c == 50) begin start_i = 1'b1; words_i = ~w; end
      if (mode == 1 && c == 51) start_i = 1'b0;
      if (mode == 2 && c == WINDOW-1) start_i = 1'b1;
      @(negedge clk);
    end
    check(berr == 0, "R1", {tag, " busy held"}, berr, 0);
    check(ferr == 0, "R2", {tag, " flag slots"}, ferr, 0);
    check(derr == 0, "R3", {tag, " serial bits"}, derr, 0);
    check(terr == 0, "R4", {tag, " idle tail"}, terr, 0);
    if (mode == 2) begin
      check(busy_o == 1'b0, "R6", "start in last cycle ignored", busy_o, 0);
      start_i = 1'b0;
      @(negedge clk);
      check(busy_o == 1'b0, "R6", "no burst from ignored start", busy_o, 0);
    end else begin
      check(busy_o == 1'b0, "R1", {tag, " busy drops after 140"}, busy_o, 1'b0);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    start_i = 1'b1;
    words_i = '1;
    repeat (3) @(negedge clk);
    check(!busy_o && !ser_o && !flag_o, "R7", "quiet during reset",
          {busy_o, ser_o, flag_o}, 0);
    start_i = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy_o && !ser_o && !flag_o, "R7", "quiet after reset",
          {busy_o, ser_o, flag_o}, 0);

    for (int i = 0; i < 4; i++) begin
      run_burst(VEC[i], 0, $sformatf("vec%0d", i));
      repeat (3) @(negedge clk);
    end

    // R5, R6: start pulse and new input words mid-burst
    run_burst(VEC[1], 1, "mid-start r5_r6");
    repeat (2) @(negedge clk);

    // R8: back-to-back start right after busy falls
    run_burst(VEC[3], 0, "first");
    run_burst(VEC[0], 0, "r8_b2b");

    // R6: start on the final window cycle is ignored
    repeat (2) @(negedge clk);
    run_burst(VEC[2], 2, "end-start");

    // R7: idle quiet with active inputs
    words_i = '1;
    repeat (5) @(negedge clk);
    check(!busy_o && !ser_o && !flag_o, "R7", "idle quiet",
          {busy_o, ser_o, flag_o}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule